// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block takes one parallel data word at a time and sends it serially on a two-rail return-to-zero output. The "one" rail pulses for a 1 bit and the "zero" rail pulses for a 0 bit. Each pulse fills the first half of the bit period, and both rails are low for the second half. The bit period is a whole number of system clocks and is chosen by a rate select: ten clocks for the fast rate and eighty clocks for the slow rate. The word can be 32 or 25 bits long. Its final position carries either a parity bit or a raw data bit. The parity sense can be flipped to even, so that a receiver's parity checker can be exercised.

Words enter through a valid/ready handshake. There is no buffering: `in_ready` is high only when the transmitter is idle. A word is taken on the clock edge where `in_valid` and `in_ready` are both high. From the next cycle, `in_ready` stays low until the word and its trailing null gap are complete. A producer facing back-pressure must hold its word and `in_valid` until `in_ready` returns. While `in_ready` is low, `in_valid` is ignored. Every configuration input is sampled on the accept edge, so a configuration change during a word takes effect only from the next word.

Top module: `arinc_word_tx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both rails are low and `in_ready` is high. Asserting reset in the middle of a word stops the word at once.
- R2: A word is accepted on the rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the transmitter is idle again. `in_valid` and `in_word` have no effect while `in_ready` is 0.
- R3: Every bit period starts with a pulse of half the period: on `tx_one` for a 1 bit, or on `tx_zero` for a 0 bit. The second half has both rails low. The two rails are never high together.
- R4: With `cfg_rate_slow` = 0 a bit period is 10 clocks (5 pulse, 5 low). With `cfg_rate_slow` = 1 it is 80 clocks (40 pulse, 40 low). Bit 0 of the word starts in the cycle right after the accept edge.
- R5: Send order: label bits `in_word[7]` down to `in_word[0]` first, then `in_word[8]`, `in_word[9]` and upward to the position just below the final position.
- R6: With `cfg_short` = 0 the word has 32 positions and the final position is `in_word[31]`. With `cfg_short` = 1 it has 25 positions and the final position is `in_word[24]`. Bits above the final position are not sent.
- R7: The parity bit makes the count of ones over all transmitted bits before the final position, plus the parity bit, odd. With `cfg_par_invert` = 1 the parity bit is inverted, giving even parity.
- R8: With `cfg_data_ctl_n` = 1 the final position always carries parity. With `cfg_data_ctl_n` = 0, `cfg_par_sel` = 1 selects parity and `cfg_par_sel` = 0 sends the raw final data bit.
- R9: Rate, length, final-bit source and parity sense are taken only on the accept edge, or while idle or in reset. Changing them during a word has no effect on that word.
- R10: After the final bit, both rails stay low for 4 bit periods. `in_ready` rises exactly (N+4) bit periods after the accept edge, where N is the word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asynchronous |
| cfg_rate_slow | input | 1 | 0: 10 clocks per bit, 1: 80 clocks per bit |
| cfg_short | input | 1 | 0: 32-bit word, 1: 25-bit word |
| cfg_data_ctl_n | input | 1 | Active-low enable for the final-bit source choice |
| cfg_par_sel | input | 1 | When enabled: 0 raw data, 1 parity in the final position |
| cfg_par_invert | input | 1 | 1 inverts the parity bit (even parity) |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter idle, word can be taken |
| in_word | input | 32 | Word to send, label in bits 7:0 |
| tx_one | output | 1 | Return-to-zero rail for 1 bits |
| tx_zero | output | 1 | Return-to-zero rail for 0 bits |

## Verification
The bench sweeps all 32 combinations of rate, length, final-bit source and parity sense, with several word patterns (including all zeros and all ones). It compares every cycle of both rails against a waveform computed from the rules above. A wrong label order or a reversed data order moves bits to the wrong slots. A parity computed over the wrong span or with the wrong sense flips only the final pulse. A wrong divider or half-period shows up as pulses of the wrong length. The bench also changes every configuration input and offers a second word in the middle of a transmission: a design that samples late would change rate, length or parity mid-word, or would start the second word early. It also checks the exact cycle `in_ready` returns, which catches a gap that is too short or a bit counter that is off by one, and it checks that a reset in the middle of a word silences the rails at once.

// File: rtl/awt_pkg.sv
package awt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } awt_state_e;
endpackage

// File: rtl/awt_bit_timer.sv
module awt_bit_timer #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow,
  output logic first_half,
  output logic bit_end
);
  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] LIM_F  = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] LIM_S  = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] HALF_F = CNT_W'(FAST_DIV / 2);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(SLOW_DIV / 2);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] half;

  assign lim        = slow ? LIM_S : LIM_F;
  assign half       = slow ? HALF_S : HALF_F;
  assign bit_end    = (cnt == lim);
  assign first_half = (cnt < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || bit_end) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim); // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0)); // R4
endmodule

// File: rtl/awt_framer.sv
module awt_framer #(
  parameter int WORD_W  = 32,
  parameter int SHORT_W = 25,
  parameter int LABEL_W = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic              short_sel,
  input  logic              ctl_n,
  input  logic              par_sel,
  input  logic              par_inv,
  output logic [WORD_W-1:0] seq
);
  logic [WORD_W-1:0]  seq_long;
  logic [SHORT_W-1:0] seq_short;
  logic use_par, par_long, par_short, last_long, last_short;

  assign use_par    = ctl_n | par_sel;
  assign par_long   = (~^word[WORD_W-2:0]) ^ par_inv;
  assign par_short  = (~^word[SHORT_W-2:0]) ^ par_inv;
  assign last_long  = use_par ? par_long  : word[WORD_W-1];
  assign last_short = use_par ? par_short : word[SHORT_W-1];

  for (genvar p = 0; p < WORD_W; p++) begin : g_long
    if (p < LABEL_W) begin : g_lab
      assign seq_long[p] = word[LABEL_W-1-p];
    end else if (p < WORD_W-1) begin : g_dat
      assign seq_long[p] = word[p];
    end else begin : g_fin
      assign seq_long[p] = last_long;
    end
  end

  for (genvar p = 0; p < SHORT_W; p++) begin : g_short
    if (p < LABEL_W) begin : g_lab
      assign seq_short[p] = word[LABEL_W-1-p];
    end else if (p < SHORT_W-1) begin : g_dat
      assign seq_short[p] = word[p];
    end else begin : g_fin
      assign seq_short[p] = last_short;
    end
  end

  assign seq = short_sel ? {{(WORD_W-SHORT_W){1'b0}}, seq_short} : seq_long;

  always_comb begin
    AST_LABEL_FIRST: assert (seq[0] == word[LABEL_W-1]); // R5
  end
endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx #(
  parameter int WORD_W   = 32,
  parameter int SHORT_W  = 25,
  parameter int LABEL_W  = 8,
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rate_slow,
  input  logic              cfg_short,
  input  logic              cfg_data_ctl_n,
  input  logic              cfg_par_sel,
  input  logic              cfg_par_invert,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              tx_one,
  output logic              tx_zero
);
  import awt_pkg::*;

  localparam int BIT_W = $clog2(WORD_W);
  localparam int GAP_W = $clog2(GAP_BITS + 1);
  localparam logic [BIT_W-1:0] LAST_L = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] LAST_S = BIT_W'(SHORT_W - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);

  awt_state_e        state;
  logic              rate_q, short_q;
  logic [WORD_W-1:0] seq_q, framed;
  logic [BIT_W-1:0]  bit_cnt, last_idx;
  logic [GAP_W-1:0]  gap_cnt;
  logic              first_half, bit_end, accept;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign last_idx = short_q ? LAST_S : LAST_L;

  awt_framer #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .LABEL_W(LABEL_W)) u_framer (
    .word(in_word), .short_sel(cfg_short), .ctl_n(cfg_data_ctl_n),
    .par_sel(cfg_par_sel), .par_inv(cfg_par_invert), .seq(framed)
  );

  awt_bit_timer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(state == ST_IDLE), .slow(rate_q),
    .first_half(first_half), .bit_end(bit_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rate_q  <= 1'b0;
      short_q <= 1'b0;
      seq_q   <= '0;
      bit_cnt <= '0;
      gap_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          rate_q <= cfg_rate_slow;
          if (accept) begin
            short_q <= cfg_short;
            seq_q   <= framed;
            bit_cnt <= '0;
            state   <= ST_SEND;
          end
        end
        ST_SEND: if (bit_end) begin
          if (bit_cnt == last_idx) begin
            gap_cnt <= '0;
            state   <= ST_GAP;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            seq_q   <= seq_q >> 1;
          end
        end
        ST_GAP: if (bit_end) begin
          if (gap_cnt == GAP_LAST) state <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_one  = (state == ST_SEND) && first_half &&  seq_q[0];
  assign tx_zero = (state == ST_SEND) && first_half && !seq_q[0];

  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_one && tx_zero)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!tx_one && !tx_zero)); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R2
  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(rate_q)); // R9
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(short_q)); // R6
  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= last_idx); // R6
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (!tx_one && !tx_zero)); // R10
endmodule

// File: tb/arinc_word_tx_bench.sv
module arinc_word_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rate_slow = 0, cfg_short = 0, cfg_data_ctl_n = 1, cfg_par_sel = 0, cfg_par_invert = 0;
  logic in_valid = 0;
  logic in_ready, tx_one, tx_zero;
  logic [31:0] in_word = '0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  arinc_word_tx u_arinc_word_tx (
    .clk(clk), .rst_n(rst_n), .cfg_rate_slow(cfg_rate_slow), .cfg_short(cfg_short),
    .cfg_data_ctl_n(cfg_data_ctl_n), .cfg_par_sel(cfg_par_sel),
    .cfg_par_invert(cfg_par_invert), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .tx_one(tx_one), .tx_zero(tx_zero)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [31:0] w, input int n, input int p,
                                 input bit ctln, input bit psel, input bit pinv);
    int ones = 0;
    if (p < 8) return w[7-p];
    if (p < n-1) return w[p];
    for (int i = 0; i < n-1; i++) ones += w[i];
    if (ctln || psel) return ((ones % 2) == 0) ^ pinv;
    return w[n-1];
  endfunction

  // Sends one word and compares every cycle of the rails and the ready flag.
  task automatic xfer(input logic [31:0] w, input bit slow, input bit shrt, input bit ctln,
                      input bit psel, input bit pinv, input bit perturb);
    int div = slow ? 80 : 10;
    int n = shrt ? 25 : 32;
    int total = (n + 4) * div;
    int bad = 0, bad_c = -1, bad_act = 0, bad_exp = 0;
    @(negedge clk);
    cfg_rate_slow = slow; cfg_short = shrt; cfg_data_ctl_n = ctln;
    cfg_par_sel = psel; cfg_par_invert = pinv; in_word = w; in_valid = 1;
    chk(in_ready === 1'b1, "R2 ready before accept", in_ready, 1);
    @(negedge clk);
    in_valid = 0; in_word = ~w;
    for (int c = 0; c < total; c++) begin
      int p = c / div;
      bit fh = (c % div) < (div / 2);
      bit b = (p < n) ? exp_bit(w, n, p, ctln, psel, pinv) : 1'b0;
      int e = {in_ready ? 1'b0 : 1'b0, (p < n) && fh && b, (p < n) && fh && !b};
      int a = {in_ready, tx_one, tx_zero};
      if (a != e && bad == 0) begin bad_c = c; bad_act = a; bad_exp = e; end
      if (a != e) bad++;
      if (perturb && c == 2) begin
        cfg_rate_slow = ~slow; cfg_short = ~shrt; cfg_data_ctl_n = ~ctln;
        cfg_par_sel = ~psel; cfg_par_invert = ~pinv; in_valid = 1; in_word = ~w;
      end
      if (perturb && c == total - 1) in_valid = 0;
      @(negedge clk);
    end
    if (bad != 0) $display("  first mismatch at cycle %0d", bad_c);
    chk(bad == 0, perturb ? "R9 R2 waveform under mid-word changes {ready,one,zero}"
                          : "R3 R4 R5 R6 R7 R8 waveform {ready,one,zero}", bad_act, bad_exp);
    chk(in_ready === 1'b1 && !tx_one && !tx_zero, "R10 ready returns after gap",
        {in_ready, tx_one, tx_zero}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && !tx_one && !tx_zero, "R1 state during reset",
        {in_ready, tx_one, tx_zero}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b1 && !tx_one && !tx_zero, "R1 state after reset",
        {in_ready, tx_one, tx_zero}, 3'b100);

    // Full sweep over the configuration space.
    for (int cfg = 0; cfg < 32; cfg++) begin
      int nw = cfg[4] ? 2 : 4;
      for (int k = 0; k < nw; k++) begin
        logic [31:0] w = 32'h9E3779B9 * (cfg * 4 + k + 1);
        if (k == 2) w = 32'h0;
        if (k == 3) w = 32'hFFFF_FFFF;
        xfer(w, cfg[4], cfg[3], cfg[2], cfg[1], cfg[0], 1'b0);
      end
    end

    // R9 / R2: configuration changes and a second offer during a word.
    xfer(32'hA5C3_1E87, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    xfer(32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    xfer(32'h0F0F_00FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a word.
    @(negedge clk);
    cfg_rate_slow = 0; cfg_short = 0; in_word = 32'hFFFF_FFFF; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (20) @(negedge clk);
    rst_n = 0;
    #1;
    chk(in_ready === 1'b1 && !tx_one && !tx_zero, "R1 mid-word reset",
        {in_ready, tx_one, tx_zero}, 3'b100);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1 && !tx_one && !tx_zero, "R1 quiet after mid-word reset",
        {in_ready, tx_one, tx_zero}, 3'b100);
    xfer(32'h8000_0081, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule